// File: doc/BRIEF.md
# Iterative Single-Precision Square Root Unit

This unit takes the square root of one IEEE 754 single-precision operand over several clock cycles. A one-cycle start strobe captures the operand, a guard bit and a 2-bit rounding mode. The mantissa root comes from a restoring digit-by-digit recurrence that retires two root bits per clock. A special-case path handles zeros, infinities, NaNs, negative operands and denormals. Seventeen clock edges after the edge that sampled the start strobe, a one-cycle result-valid strobe carries the 32-bit result. In the same cycle come a write enable and four exception flags: invalid, inexact, input-flushed and output-flushed.

The flags appear in the same cycle as the result, so the surrounding datapath can OR them into its own sticky status register. That register, and any merging of flags from other units, lives outside this block. If the guard bit is low, the operation still runs and still produces its valid strobe. The write enable then stays low and all flags read zero, so nothing downstream changes. The engine accepts a new operation every 16 cycles. The next operation can therefore be taken on the same edge on which the previous result moves into the output stage.

Top module: `fp_sqrt_seq`

## Requirements
- R1: With rounding mode 2'b00 (nearest, ties to even), a positive normal operand yields the correctly rounded single-precision root. The flag_inexact output is high exactly when the root is not exact (for example 0x40400000 gives 0x3FDDB3D7 with inexact, 0x7F7FFFFF gives 0x5F7FFFFF with inexact, 0x00C00000 gives 0x201CC471 with inexact, 0x3F800000 gives 0x3F800000 with no flag).
- R2: Rounding mode 2'b01 truncates toward zero, 2'b10 rounds toward +infinity and 2'b11 rounds toward -infinity. Roots are positive, so 2'b11 gives the same result as 2'b01. A carry out of the mantissa increments the exponent field. Inexact is flagged as in R1.
- R3: An operand whose exponent field is 0 and whose fraction is nonzero is replaced by a zero of the same sign. The result is that signed zero, with flag_in_flush high and no other flag.
- R4: flag_out_flush is never asserted, because the root of any positive normal operand is a normal number.
- R5: Any of the following returns 0xFFFFFFFF with flag_invalid high: a negative normal operand, -infinity (0xFF800000), or a signalling NaN (exponent field all ones, fraction nonzero, fraction bit 22 = 0). A quiet NaN (fraction bit 22 = 1) returns 0xFFFFFFFF with no flag.
- R6: +0 and -0 return themselves, and +infinity (0x7F800000) returns +infinity, all with no flag.
- R7: res_valid is a one-cycle pulse that appears 17 clock edges after the edge that sampled an accepted start, and at no other time.
- R8: A start is accepted when the unit is idle, or 16 edges after the previous accepted start. A start on any of the 15 edges in between is ignored and changes neither the pending result nor the number of valid pulses.
- R9: If the captured guard bit is 1, wr_en is high with res_valid and the flags are driven. If it is 0, res_valid still pulses, wr_en stays low and all four flags are 0.
- R10: After synchronous reset, res_valid, wr_en and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue strobe, sampled on the rising edge |
| operand | input | 32 | Single-precision operand |
| guard | input | 1 | 1 lets the result and flags be written |
| rmode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| res_valid | output | 1 | One-cycle strobe marking the result cycle |
| wr_en | output | 1 | Result write enable (valid and guard) |
| result | output | 32 | Single-precision root |
| flag_invalid | output | 1 | Invalid operation |
| flag_inexact | output | 1 | Result was rounded |
| flag_in_flush | output | 1 | Denormal operand was flushed to zero |
| flag_out_flush | output | 1 | Denormal result was flushed to zero |

## Verification
Random positive normals across the full exponent range, with every rounding mode, separate round-up from truncation and test the exponent parity split, since odd and even exponents load the radicand at different alignments. Directed near-four operands such as 0x407FFFFF show whether a rounding carry out of the mantissa reaches the exponent. Fully random bit patterns land on NaN, infinity, denormal and negative encodings and show whether the special-case path or the recurrence drives the result. Back-to-back issues 16 cycles apart and a start injected mid-operation show whether the issue window is enforced, and guard-low operations show whether flags are suppressed while the valid timing is kept.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    localparam int WORD_W    = 32;
    localparam int EXP_W     = 8;
    localparam int FRAC_W    = 23;
    localparam int MANT_W    = FRAC_W + 1;
    // root carries hidden bit, fraction, a round bit and one extra bit
    localparam int ROOT_W    = MANT_W + 2;
    localparam int DIG_PER_CYC = 2;
    localparam int N_ITER    = ROOT_W / DIG_PER_CYC;
    localparam int RAD_W     = 2 * ROOT_W;
    localparam int REM_W     = ROOT_W + 2;
    // radicand shift for an odd biased exponent; even adds one
    localparam int SH_BASE   = 2 * (ROOT_W - 1) - FRAC_W;
    localparam int ISSUE_GAP = 16;
    localparam int LATENCY   = ISSUE_GAP + 1;
    localparam int CNT_W     = $clog2(ISSUE_GAP);
    localparam logic [EXP_W:0] HALF_BIAS_M1 = 9'd126;

    localparam logic [WORD_W-1:0] QNAN_WORD = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] PINF_WORD = 32'h7F80_0000;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_POS  = 2'b10,
        RM_NEG  = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        K_NORM,
        K_ZERO,
        K_DENORM,
        K_PINF,
        K_INVALID,
        K_QNAN
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic             sign;
        logic [EXP_W-1:0] exp;
    } opnd_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              inv;
        logic              inx;
        logic              ifz;
        logic              ofz;
    } outc_t;

    function automatic kind_e classify(input logic [WORD_W-1:0] w);
        kind_e k;
        if (w[WORD_W-2 -: EXP_W] == '1) begin
            if (w[FRAC_W-1:0] != '0)
                k = w[FRAC_W-1] ? K_QNAN : K_INVALID;
            else
                k = w[WORD_W-1] ? K_INVALID : K_PINF;
        end else if (w[WORD_W-2 -: EXP_W] == '0) begin
            k = (w[FRAC_W-1:0] == '0) ? K_ZERO : K_DENORM;
        end else begin
            k = w[WORD_W-1] ? K_INVALID : K_NORM;
        end
        return k;
    endfunction

endpackage

// File: rtl/fsq_unpack.sv
module fsq_unpack
    import fsq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output opnd_t             op,
    output logic [MANT_W-1:0] mant
);

    always_comb begin
        op.kind = classify(word);
        op.sign = word[WORD_W-1];
        op.exp  = word[WORD_W-2 -: EXP_W];
        mant    = {1'b1, word[FRAC_W-1:0]};
    end

endmodule

// File: rtl/fsq_root_core.sv
module fsq_root_core
    import fsq_pkg::*;
#(
    parameter int RW  = ROOT_W,
    parameter int AW  = RAD_W,
    parameter int MW  = REM_W,
    parameter int DPC = DIG_PER_CYC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] rad_in,
    output logic [RW-1:0] root,
    output logic          rem_nz
);

    logic [AW-1:0] rad_q;
    logic [MW-1:0] rem_q;
    logic [RW-1:0] root_q;

    logic [AW-1:0] rad_c  [DPC+1];
    logic [MW-1:0] rem_c  [DPC+1];
    logic [RW-1:0] root_c [DPC+1];

    assign rad_c[0]  = rad_q;
    assign rem_c[0]  = rem_q;
    assign root_c[0] = root_q;

    for (genvar g = 0; g < DPC; g++) begin : g_digit
        logic [MW-1:0] cand;
        logic [MW-1:0] trial;
        logic          ge;
        assign cand  = {rem_c[g][MW-3:0], rad_c[g][AW-1 -: 2]};
        assign trial = {root_c[g], 2'b01};
        // upper remainder bits are zero in range; a set bit still means >=
        assign ge    = (rem_c[g][MW-1 -: 2] != 2'b00) || (cand >= trial);
        assign rem_c[g+1]  = ge ? (cand - trial) : cand;
        assign root_c[g+1] = {root_c[g][RW-2:0], ge};
        assign rad_c[g+1]  = rad_c[g] << 2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rad_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
        end else if (load) begin
            rad_q  <= rad_in;
            rem_q  <= '0;
            root_q <= '0;
        end else if (step) begin
            rad_q  <= rad_c[DPC];
            rem_q  <= rem_c[DPC];
            root_q <= root_c[DPC];
        end
    end

    assign root   = root_q;
    assign rem_nz = |rem_q;

endmodule

// File: rtl/fsq_round.sv
module fsq_round
    import fsq_pkg::*;
(
    input  opnd_t             op,
    input  rmode_e            rm,
    input  logic [ROOT_W-1:0] root,
    input  logic              rem_nz,
    output outc_t             res
);

    logic [EXP_W:0]            esum;
    logic [EXP_W-1:0]          exp_r;
    logic                      lsb_b, rnd_b, stk_b, up;
    logic [WORD_W-2:0]         mag;

    always_comb begin
        // the hidden root bit completes the bias add: (e + 127) >> 1
        esum  = {1'b0, op.exp} + HALF_BIAS_M1 + {{EXP_W{1'b0}}, root[ROOT_W-1]};
        exp_r = esum[EXP_W:1];
        lsb_b = root[2];
        rnd_b = root[1];
        stk_b = root[0] | rem_nz;
        case (rm)
            RM_NEAR: up = rnd_b & (stk_b | lsb_b);
            RM_POS:  up = rnd_b | stk_b;
            default: up = 1'b0;
        endcase
        mag = {exp_r, root[ROOT_W-2 -: FRAC_W]} + {{(WORD_W-2){1'b0}}, up};

        res = '0;
        case (op.kind)
            K_NORM: begin
                res.word = {1'b0, mag};
                res.inx  = rnd_b | stk_b;
            end
            K_ZERO:    res.word = {op.sign, {(WORD_W-1){1'b0}}};
            K_DENORM: begin
                res.word = {op.sign, {(WORD_W-1){1'b0}}};
                res.ifz  = 1'b1;
            end
            K_PINF:    res.word = PINF_WORD;
            K_INVALID: begin
                res.word = QNAN_WORD;
                res.inv  = 1'b1;
            end
            default:   res.word = QNAN_WORD;
        endcase
    end

endmodule

// File: rtl/fp_sqrt_seq.sv
module fp_sqrt_seq
    import fsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] operand,
    input  logic              guard,
    input  logic [1:0]        rmode,
    output logic              res_valid,
    output logic              wr_en,
    output logic [WORD_W-1:0] result,
    output logic              flag_invalid,
    output logic              flag_inexact,
    output logic              flag_in_flush,
    output logic              flag_out_flush
);

    opnd_t             op_c, op_q;
    logic [MANT_W-1:0] mant_c;
    logic              guard_q;
    rmode_e            rm_q;
    logic              busy;
    logic [CNT_W-1:0]  cnt;
    logic              accept, step, finish;
    logic [RAD_W-1:0]  rad_c;
    logic [ROOT_W-1:0] root_w;
    logic              rem_nz_w;
    outc_t             rnd_c, fin_q, out_q;
    logic              fin_v, fin_g, out_v, out_g;

    fsq_unpack u_unpack (
        .word (operand),
        .op   (op_c),
        .mant (mant_c)
    );

    assign finish = busy && (cnt == CNT_W'(ISSUE_GAP - 1));
    assign accept = start && (!busy || finish);
    assign step   = busy && (cnt < CNT_W'(N_ITER));
    // odd biased exponent -> even true exponent -> smaller alignment
    assign rad_c  = op_c.exp[0] ? (RAD_W'(mant_c) << SH_BASE)
                                : (RAD_W'(mant_c) << (SH_BASE + 1));

    fsq_root_core u_core (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .step   (step),
        .rad_in (rad_c),
        .root   (root_w),
        .rem_nz (rem_nz_w)
    );

    fsq_round u_round (
        .op     (op_q),
        .rm     (rm_q),
        .root   (root_w),
        .rem_nz (rem_nz_w),
        .res    (rnd_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            op_q    <= '0;
            guard_q <= 1'b0;
            rm_q    <= RM_NEAR;
            fin_q   <= '0;
            fin_v   <= 1'b0;
            fin_g   <= 1'b0;
            out_q   <= '0;
            out_v   <= 1'b0;
            out_g   <= 1'b0;
        end else begin
            fin_v <= finish;
            if (finish) begin
                fin_q <= rnd_c;
                fin_g <= guard_q;
            end
            if (accept) begin
                busy    <= 1'b1;
                cnt     <= '0;
                op_q    <= op_c;
                guard_q <= guard;
                rm_q    <= rmode_e'(rmode);
            end else if (finish) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
            end
            out_v <= fin_v;
            out_g <= fin_v & fin_g;
            if (fin_v)
                out_q <= fin_q;
        end
    end

    assign res_valid      = out_v;
    assign wr_en          = out_g;
    assign result         = out_q.word;
    assign flag_invalid   = out_g & out_q.inv;
    assign flag_inexact   = out_g & out_q.inx;
    assign flag_in_flush  = out_g & out_q.ifz;
    assign flag_out_flush = out_g & out_q.ofz;

endmodule

// File: rtl/fsq_chk.sv
module fsq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        res_valid,
    input logic        wr_en,
    input logic [31:0] result,
    input logic        flag_invalid,
    input logic        flag_inexact,
    input logic        flag_in_flush,
    input logic        flag_out_flush
);

    logic [4:0]  gap;
    logic        live;
    logic [17:0] acc_sr;
    logic        acc;

    assign acc = start && (!live || gap >= 5'd16);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap    <= '0;
            live   <= 1'b0;
            acc_sr <= '0;
        end else begin
            acc_sr <= {acc_sr[16:0], acc};
            if (acc) begin
                live <= 1'b1;
                gap  <= 5'd1;
            end else if (live && gap != 5'd31) begin
                gap <= gap + 5'd1;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        res_valid == acc_sr[17]);                                          // R7 R8
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);                                         // R7
    AST_WREN_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> res_valid);                                              // R9
    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !(flag_invalid | flag_inexact | flag_in_flush | flag_out_flush)); // R9
    AST_INV_NAN: assert property (@(posedge clk) disable iff (rst)
        flag_invalid |-> (result == 32'hFFFF_FFFF));                       // R5
    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (rst)
        flag_in_flush |-> (result[30:0] == 31'd0 && !flag_inexact));       // R3
    AST_NO_OUT_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !flag_out_flush);                                                  // R4
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones({flag_invalid, flag_inexact, flag_in_flush}) <= 1);     // R1

endmodule

bind fp_sqrt_seq fsq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .res_valid      (res_valid),
    .wr_en          (wr_en),
    .result         (result),
    .flag_invalid   (flag_invalid),
    .flag_inexact   (flag_inexact),
    .flag_in_flush  (flag_in_flush),
    .flag_out_flush (flag_out_flush)
);

// File: tb/sim_fp_sqrt_seq.sv
`timescale 1ns/1ps
module sim_fp_sqrt_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic        guard = 1'b0;
    logic [1:0]  rmode = 2'b00;
    logic        res_valid, wr_en;
    logic [31:0] result;
    logic        flag_invalid, flag_inexact, flag_in_flush, flag_out_flush;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] last_res;

    always #4 clk = ~clk;

    fp_sqrt_seq u0 (
        .clk(clk), .rst(rst), .start(start), .operand(operand), .guard(guard),
        .rmode(rmode), .res_valid(res_valid), .wr_en(wr_en), .result(result),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
        .flag_in_flush(flag_in_flush), .flag_out_flush(flag_out_flush)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference: {word, invalid, inexact, in_flush, out_flush}
    function automatic logic [35:0] model(input logic [31:0] w, input logic [1:0] rm);
        logic [7:0]  e;
        logic [22:0] f;
        longint      x, q;
        logic        up, inx;
        logic [7:0]  re;
        logic [30:0] mag;
        e = w[30:23];
        f = w[22:0];
        if (e == 8'hFF) begin
            if (f != 0) return {32'hFFFFFFFF, ~f[22], 3'b000};
            if (w[31])  return {32'hFFFFFFFF, 4'b1000};
            return {32'h7F800000, 4'b0000};
        end
        if (e == 8'h00) return {w[31], 31'd0, 2'b00, (f != 0), 1'b0};
        if (w[31]) return {32'hFFFFFFFF, 4'b1000};
        x = longint'({1'b1, f}) << (e[0] ? 23 : 24);
        q = longint'($sqrt(real'(x)));
        while (q * q > x) q--;
        while ((q + 1) * (q + 1) <= x) q++;
        inx = (q * q != x);
        case (rm)
            2'b00:   up = (4 * x > (2 * q + 1) * (2 * q + 1));
            2'b10:   up = inx;
            default: up = 1'b0;
        endcase
        re  = 8'((int'(e) + 127) / 2);
        mag = {re, q[22:0]} + 31'(up);
        return {1'b0, mag, 1'b0, inx, 2'b00};
    endfunction

    function automatic string tag_of(input logic [31:0] w, input logic [1:0] rm);
        if (w[30:23] == 8'hFF) return (w[22:0] != 0 || w[31]) ? "R5" : "R6";
        if (w[30:23] == 8'h00) return (w[22:0] != 0) ? "R3" : "R6";
        if (w[31]) return "R5";
        return (rm == 2'b00) ? "R1" : "R2";
    endfunction

    task automatic check_out(input logic [31:0] w, input bit g, input logic [1:0] rm);
        logic [35:0] e;
        string t;
        e = model(w, rm);
        t = tag_of(w, rm);
        chk(res_valid == 1'b1, "R7 valid", 64'(res_valid), 64'd1);
        chk(wr_en == g, "R9 wr_en", 64'(wr_en), 64'(g));
        chk(flag_out_flush == 1'b0, "R4 out_flush", 64'(flag_out_flush), 64'd0);
        if (g) begin
            chk(result == e[35:4], {t, " result"}, 64'(result), 64'(e[35:4]));
            chk({flag_invalid, flag_inexact, flag_in_flush, flag_out_flush} == e[3:0],
                {t, " flags"}, 64'({flag_invalid, flag_inexact, flag_in_flush, flag_out_flush}),
                64'(e[3:0]));
        end else begin
            chk({flag_invalid, flag_inexact, flag_in_flush, flag_out_flush} == 4'b0,
                "R9 guard-low flags",
                64'({flag_invalid, flag_inexact, flag_in_flush, flag_out_flush}), 64'd0);
        end
        last_res = result;
    endtask

    // called at a falling edge; returns at the falling edge of the valid cycle
    task automatic run_op(input logic [31:0] w, input bit g, input logic [1:0] rm);
        start = 1'b1; operand = w; guard = g; rmode = rm;
        @(negedge clk);
        start = 1'b0; operand = $urandom; guard = ~g; rmode = 2'($urandom);
        repeat (16) @(negedge clk);
        chk(res_valid == 1'b0, "R7 early", 64'(res_valid), 64'd0);
        @(negedge clk);
        check_out(w, g, rm);
    endtask

    task automatic back_to_back(input logic [31:0] a, input logic [31:0] b);
        start = 1'b1; operand = a; guard = 1'b1; rmode = 2'b00;
        @(negedge clk);
        start = 1'b0;
        repeat (15) @(negedge clk);
        start = 1'b1; operand = b; guard = 1'b1; rmode = 2'b00;
        @(negedge clk);
        start = 1'b0;
        chk(res_valid == 1'b0, "R8 b2b early", 64'(res_valid), 64'd0);
        @(negedge clk);
        check_out(a, 1'b1, 2'b00);
        repeat (15) @(negedge clk);
        chk(res_valid == 1'b0, "R8 b2b second early", 64'(res_valid), 64'd0);
        @(negedge clk);
        check_out(b, 1'b1, 2'b00);
    endtask

    task automatic ignored_start(input logic [31:0] a, input logic [31:0] x);
        bit extra;
        start = 1'b1; operand = a; guard = 1'b1; rmode = 2'b00;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1; operand = x; guard = 1'b1; rmode = 2'b10;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        check_out(a, 1'b1, 2'b00);
        extra = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (res_valid) extra = 1'b1;
        end
        chk(extra == 1'b0, "R8 ignored start pulse", 64'(extra), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [1:0]  rm;
        bit          g;
        w = $urandom(32'd1337);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk({res_valid, wr_en, flag_invalid, flag_inexact, flag_in_flush, flag_out_flush} == 6'b0,
            "R10 reset", 64'({res_valid, wr_en, flag_invalid, flag_inexact,
                              flag_in_flush, flag_out_flush}), 64'd0);

        run_op(32'h40400000, 1'b1, 2'b00);
        chk(last_res == 32'h3FDDB3D7, "R1 literal 3.0", 64'(last_res), 64'h3FDDB3D7);
        run_op(32'h7F7FFFFF, 1'b1, 2'b00);
        chk(last_res == 32'h5F7FFFFF, "R1 literal max", 64'(last_res), 64'h5F7FFFFF);
        run_op(32'h00C00000, 1'b1, 2'b00);
        chk(last_res == 32'h201CC471, "R1 literal small", 64'(last_res), 64'h201CC471);
        run_op(32'h3F800000, 1'b1, 2'b00);
        run_op(32'h40800000, 1'b1, 2'b10);
        run_op(32'h407FFFFF, 1'b1, 2'b10);   // R2 mantissa carry into exponent
        run_op(32'h407FFFFF, 1'b1, 2'b01);
        run_op(32'h40400000, 1'b1, 2'b11);
        run_op(32'h40400000, 1'b0, 2'b00);   // R9 guard low
        run_op(32'hC0400000, 1'b1, 2'b00);   // R5
        run_op(32'hFF800000, 1'b1, 2'b00);
        run_op(32'h7F800001, 1'b1, 2'b00);
        run_op(32'h7FC00000, 1'b1, 2'b00);
        run_op(32'h7F800000, 1'b1, 2'b00);   // R6
        run_op(32'h00000000, 1'b1, 2'b00);
        run_op(32'h80000000, 1'b1, 2'b00);
        run_op(32'h00400000, 1'b1, 2'b00);   // R3
        run_op(32'h80000001, 1'b1, 2'b10);
        run_op(32'hC0400000, 1'b0, 2'b00);   // R9 guard low hides invalid
        back_to_back(32'h40400000, 32'h41200000);
        ignored_start(32'h3FC00000, 32'hC0000000);

        for (int n = 0; n < 300; n++) begin
            if (($urandom % 8) < 5)
                w = {1'b0, 8'(1 + $urandom % 254), 23'($urandom)};
            else
                w = $urandom;
            rm = 2'($urandom);
            g  = (($urandom % 8) != 0);
            run_op(w, g, rm);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule